// File: doc/BRIEF.md
# Bit-Serial Floating-Point Multiplier with Alternating Partial-Sum Columns

The block multiplies two packed floating-point operands, each made of a sign bit, a biased exponent field and a fraction field with an implied leading one. The significand product is formed bit-serially. In each iteration one bit of the multiplier significand, taken least significant first, gates a shifted copy of the multiplicand significand. That gated copy is added to the running partial sum. The partial sum lives in two storage columns. In every iteration one column is read and the other is written with the new sum, and then the two swap roles. After the last iteration the column written last holds the full product.

The sign and exponent come from small gate-level logic. The product sign is the XOR of the operand signs. The exponent is built by ripple additions of the two exponent fields, a correction of one and the negated bias, using only AND, OR and XOR gates. The product is normalised by at most one position and then truncated. Subnormals, zeros, NaN and infinity are not handled. Exponents that leave the field range wrap modulo 2^EXP_W, so the caller must keep them in range.

Operands enter through a valid/ready handshake. `in_ready` is high only while the block is idle, and a pair is taken on a clock edge where `in_valid` and `in_ready` are both high. The result leaves through a valid/ready handshake as well. `out_valid` stays high and `out_product` stays unchanged until the consumer raises `out_ready`. While the result waits, no new operands are taken, so back-pressure at the output stalls the input. `busy` is a plain status pin.

Top module: `fpm_serial_mul`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `busy` is 0.
- R2: Operands are taken only on an edge with `in_valid` and `in_ready` both high. While `busy` is high, `in_ready` is 0, and operand values presented then have no effect on the result.
- R3: `out_valid` rises exactly MAN_W+1 clock edges after the edge that takes the operands, which is one iteration for each significand bit.
- R4: Bit [W-1] of `out_product` is the XOR of bit [W-1] of both operands.
- R5: Let P be the product of the two significands {1,fraction}, 2*(MAN_W+1) bits wide. The fraction field `out_product[MAN_W-1:0]` holds the MAN_W bits of P just below its leading one, and the lower bits are dropped. The leading one is the top bit of P when that bit is set, and otherwise the next bit down.
- R6: The exponent field `out_product[W-2:MAN_W]` equals exp_a + exp_b − (2^(EXP_W−1) − 1), plus 1 when the top bit of P is set.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_product` stays unchanged.
- R8: In each iteration exactly one partial-sum column is written, and the column being read stays unchanged. The column select toggles on every iteration, and the result is taken from the column written last.
- R9: One edge after an edge with `out_valid` and `out_ready` both high, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to take operands |
| in_a | input | 1+EXP_W+MAN_W | Multiplicand {sign, exponent, fraction} |
| in_b | input | 1+EXP_W+MAN_W | Multiplier {sign, exponent, fraction} |
| busy | output | 1 | An operation is in flight or its result is waiting |
| out_valid | output | 1 | Product available |
| out_ready | input | 1 | Consumer takes the product |
| out_product | output | 1+EXP_W+MAN_W | Packed product {sign, exponent, fraction} |

## Verification
The bound checker watches the column discipline on every cycle. During an iteration the select must flip and the column being read must not move. It also checks, cycle by cycle, that no operands are taken while busy, that a held result stays frozen under back-pressure, that the block returns to idle after release, and that the latency counted from the accepting edge is exact. The numerical content cannot be checked per cycle: the sign, the normalised and truncated fraction, and the exponent with its carry correction. The bench shows it through directed operand pairs that cover products with and without a carry into the top bit, all-ones fractions where truncation matters, alternating multiplier bit patterns, and mixed signs. A further scenario offers new operands while busy and confirms the result is unaffected.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [1:0] {
    FPM_IDLE = 2'd0,
    FPM_RUN  = 2'd1,
    FPM_DONE = 2'd2
  } fpm_state_e;
endpackage

// File: rtl/fpm_ripple_add.sv
// Gate-level ripple adder built only from AND, OR and XOR; carry out discarded.
module fpm_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum
);
  logic [W-1:0] carry;
  assign carry[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  end
endmodule

// File: rtl/fpm_exp_unit.sv
// Result exponent: ea + eb + top_set - bias, modulo 2^EXP_W.
module fpm_exp_unit #(
  parameter int EXP_W = 8
) (
  input  logic [EXP_W-1:0] ea,
  input  logic [EXP_W-1:0] eb,
  input  logic             top_set,
  output logic [EXP_W-1:0] exp_out
);
  localparam logic [EXP_W-1:0] BIAS = EXP_W'((1 << (EXP_W - 1)) - 1);
  logic [EXP_W-1:0] raw_sum;

  fpm_ripple_add #(.W(EXP_W)) u_sum (
    .a(ea), .b(eb), .cin(top_set), .sum(raw_sum)
  );
  // subtract bias as add of its inverse with carry-in 1
  fpm_ripple_add #(.W(EXP_W)) u_unbias (
    .a(raw_sum), .b(~BIAS), .cin(1'b1), .sum(exp_out)
  );
endmodule

// File: rtl/fpm_pingpong_acc.sv
// Two partial-sum columns; one is read and the other written each step.
module fpm_pingpong_acc #(
  parameter int PW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step_en,
  input  logic [PW-1:0] addend,
  output logic          sel,
  output logic [PW-1:0] col0,
  output logic [PW-1:0] col1
);
  logic [PW-1:0] col_q [2];
  logic [PW-1:0] rd_col;
  logic [PW-1:0] wr_val;

  assign rd_col = sel ? col_q[1] : col_q[0];
  assign wr_val = rd_col + addend;

  always_ff @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n || clear) begin
        col_q[k] <= '0;
      end else if (step_en && (sel != 1'(k))) begin
        col_q[k] <= wr_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      sel <= 1'b0;
    end else if (step_en) begin
      sel <= ~sel;
    end
  end

  assign col0 = col_q[0];
  assign col1 = col_q[1];
endmodule

// File: rtl/fpm_ctrl.sv
// Sequencer: idle -> one step per significand bit -> hold result.
module fpm_ctrl #(
  parameter int SIG_W = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic accept,
  output logic step_en,
  output logic in_ready,
  output logic out_valid,
  output logic busy
);
  import fpm_pkg::*;
  localparam int CNT_W = (SIG_W > 1) ? $clog2(SIG_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SIG_W - 1);

  fpm_state_e       state;
  logic [CNT_W-1:0] step_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= FPM_IDLE;
      step_cnt <= '0;
    end else begin
      unique case (state)
        FPM_IDLE: if (in_valid) begin
          state    <= FPM_RUN;
          step_cnt <= '0;
        end
        FPM_RUN: begin
          step_cnt <= step_cnt + 1'b1;
          if (step_cnt == LAST) state <= FPM_DONE;
        end
        FPM_DONE: if (out_ready) state <= FPM_IDLE;
        default: state <= FPM_IDLE;
      endcase
    end
  end

  assign in_ready  = (state == FPM_IDLE);
  assign accept    = in_ready && in_valid;
  assign step_en   = (state == FPM_RUN);
  assign out_valid = (state == FPM_DONE);
  assign busy      = !in_ready;
endmodule

// File: rtl/fpm_serial_mul.sv
module fpm_serial_mul #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         busy,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_product
);
  localparam int SIG_W = MAN_W + 1;
  localparam int PW    = 2 * SIG_W;

  logic             accept, step_en;
  logic             sign_a, sign_b;
  logic [EXP_W-1:0] exp_a, exp_b, exp_res;
  logic [PW-1:0]    mcand_sh;
  logic [SIG_W-1:0] mplier_sh;
  logic [PW-1:0]    addend;
  logic             col_sel;
  logic [PW-1:0]    col0, col1;
  logic [MAN_W+1:0] prod_hi;
  logic             top_set;
  logic [MAN_W-1:0] frac_res;

  fpm_ctrl #(.SIG_W(SIG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .accept(accept), .step_en(step_en), .in_ready(in_ready),
    .out_valid(out_valid), .busy(busy)
  );

  // operand registers; multiplicand shifts up, multiplier shifts down
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sign_a <= 1'b0; sign_b <= 1'b0;
      exp_a <= '0; exp_b <= '0;
      mcand_sh <= '0; mplier_sh <= '0;
    end else if (accept) begin
      sign_a    <= in_a[W-1];
      sign_b    <= in_b[W-1];
      exp_a     <= in_a[W-2:MAN_W];
      exp_b     <= in_b[W-2:MAN_W];
      mcand_sh  <= PW'({1'b1, in_a[MAN_W-1:0]});
      mplier_sh <= {1'b1, in_b[MAN_W-1:0]};
    end else if (step_en) begin
      mcand_sh  <= mcand_sh << 1;
      mplier_sh <= mplier_sh >> 1;
    end
  end

  assign addend = mcand_sh & {PW{mplier_sh[0]}};

  fpm_pingpong_acc #(.PW(PW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(accept), .step_en(step_en),
    .addend(addend), .sel(col_sel), .col0(col0), .col1(col1)
  );

  // after the last step the select points at the column written last
  assign prod_hi  = col_sel ? col1[PW-1 -: MAN_W+2] : col0[PW-1 -: MAN_W+2];
  assign top_set  = prod_hi[MAN_W+1];
  assign frac_res = top_set ? prod_hi[MAN_W:1] : prod_hi[MAN_W-1:0];

  fpm_exp_unit #(.EXP_W(EXP_W)) u_exp (
    .ea(exp_a), .eb(exp_b), .top_set(top_set), .exp_out(exp_res)
  );

  assign out_product = {sign_a ^ sign_b, exp_res, frac_res};
endmodule

// File: rtl/fpm_serial_mul_chk.sv
module fpm_serial_mul_chk #(
  parameter int W     = 32,
  parameter int SIG_W = 24,
  parameter int PW    = 48
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          busy,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_product,
  input logic          step_en,
  input logic          col_sel,
  input logic [PW-1:0] col0,
  input logic [PW-1:0] col1
);
  logic [15:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_cnt <= '0;
    else if (in_valid && in_ready) lat_cnt <= '0;
    else if (busy && !out_valid) lat_cnt <= lat_cnt + 1'b1;
  end

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R2
  AST_EXACT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == 16'(SIG_W))); // R3
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_product))); // R7
  AST_SEL_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (col_sel != $past(col_sel))); // R8
  AST_READ_COL0_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !col_sel) |=> $stable(col0)); // R8
  AST_READ_COL1_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && col_sel) |=> $stable(col1)); // R8
  AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid)); // R9
endmodule

bind fpm_serial_mul fpm_serial_mul_chk #(
  .W(W), .SIG_W(SIG_W), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
  .out_product(out_product), .step_en(step_en), .col_sel(col_sel),
  .col0(col0), .col1(col1)
);

// File: tb/tb_fpm_serial_mul.sv
module tb_fpm_serial_mul;
  localparam int CLK_P = 10;
  localparam int EW    = 8;
  localparam int MW    = 23;
  localparam int SW    = MW + 1;
  localparam int PW    = 2 * SW;
  localparam int W     = 1 + EW + MW;
  localparam int BIAS  = (1 << (EW - 1)) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_ready, busy, out_valid;
  logic [W-1:0] out_product;
  int checks = 0;
  int errors = 0;

  fpm_serial_mul #(.EXP_W(EW), .MAN_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_product(out_product)
  );

  always #(CLK_P / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [PW-1:0] p;
    logic [MW-1:0] fr;
    int e;
    p = PW'({1'b1, a[MW-1:0]}) * PW'({1'b1, b[MW-1:0]});
    e = int'(a[W-2:MW]) + int'(b[W-2:MW]) - BIAS;
    if (p[PW-1]) begin
      e++;
      fr = p[PW-2 -: MW];
    end else begin
      fr = p[PW-3 -: MW];
    end
    return {a[W-1] ^ b[W-1], EW'(e), fr};
  endfunction

  // drive a pair at a falling edge; returns at the falling edge after acceptance
  task automatic start_op(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_result(output int n);
    n = 0;
    while (!out_valid && n < 1000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic release_result(input string tag);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(in_ready && !out_valid, "R9", {tag, " idle after release"},
          W'({in_ready, out_valid}), W'(2'b10));
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(in_ready == 1'b1, "R1", "in_ready after reset", W'(in_ready), W'(1));
    check(out_valid == 1'b0, "R1", "out_valid after reset", W'(out_valid), W'(0));
    check(busy == 1'b0, "R1", "busy after reset", W'(busy), W'(0));
  endtask

  task automatic test_mul(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic [W-1:0] e;
    int n;
    e = model(a, b);
    start_op(a, b);
    check(busy && !in_ready, "R2", {tag, " busy and not ready"},
          W'({busy, in_ready}), W'(2'b10));
    wait_result(n);
    check(n == SW, "R3", {tag, " latency"}, W'(n), W'(SW));
    check(out_product[W-1] == e[W-1], "R4", {tag, " sign"}, out_product, e);
    check(out_product[MW-1:0] == e[MW-1:0], "R5", {tag, " fraction"}, out_product, e);
    check(out_product[W-2:MW] == e[W-2:MW], "R6", {tag, " exponent"}, out_product, e);
    release_result(tag);
  endtask

  task automatic test_backpressure();
    logic [W-1:0] a, b, e, first;
    int n;
    a = {1'b1, 8'd130, 23'h2B3C4D};
    b = {1'b0, 8'd120, 23'h1F0F0F};
    e = model(a, b);
    start_op(a, b);
    wait_result(n);
    first = out_product;
    check(first == e, "R5", "held product value", first, e);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(out_valid && out_product == first, "R7", "result held under back-pressure",
            out_product, first);
      check(!in_ready, "R2", "no acceptance while result waits", W'(in_ready), W'(0));
    end
    release_result("backpressure");
  endtask

  task automatic test_ignore_while_busy();
    logic [W-1:0] a, b, e;
    int n;
    a = {1'b0, 8'd127, 23'h600000};
    b = {1'b1, 8'd125, 23'h0C0000};
    e = model(a, b);
    start_op(a, b);
    in_a = {1'b1, 8'd200, 23'h7FFFFF};
    in_b = {1'b1, 8'd50, 23'h123456};
    in_valid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(!in_ready, "R2", "in_ready low while busy", W'(in_ready), W'(0));
    end
    in_valid = 1'b0;
    wait_result(n);
    check(out_product == e, "R2", "operands offered while busy ignored", out_product, e);
    release_result("ignore");
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_mul({1'b0, 8'd127, 23'h000000}, {1'b0, 8'd127, 23'h000000}, "one_times_one");
    test_mul({1'b0, 8'd127, 23'h400000}, {1'b1, 8'd127, 23'h400000}, "carry_into_top");
    test_mul({1'b1, 8'd140, 23'h7FFFFF}, {1'b1, 8'd110, 23'h7FFFFF}, "all_ones_truncate");
    test_mul({1'b0, 8'd100, 23'h2AAAAA}, {1'b0, 8'd150, 23'h555555}, "R8_alternating_bits");
    test_mul({1'b1, 8'd1, 23'h000001}, {1'b0, 8'd126, 23'h000001}, "low_exponent");
    test_mul({1'b0, 8'd127, 23'h3504F3}, {1'b0, 8'd127, 23'h3504F3}, "near_two");
    test_backpressure();
    test_ignore_while_busy();
    test_mul({1'b1, 8'd128, 23'h123456}, {1'b0, 8'd129, 23'h654321}, "back_to_back");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule